// File: doc/BRIEF.md
# PCM Voice Frame Port

This block is the serial voice-data port of a telephone codec. It runs on the external bit clock and watches an 8 kHz frame sync. Once per frame it shifts one transmit word out on a tri-state serial output, carried on chip as a data bit plus an output enable. It also captures one receive word from a serial input. A 2-bit mode field selects one of four layouts. Companded 8-bit frames come in a long or a short variant, and the port picks the variant by measuring the width of the sync pulse. The other layouts are 16-bit linear and two fixed-offset channels for a ping-pong line transceiver.

On the parallel side the port takes a transmit word and returns a receive word together with a one-period frame-done strobe. Companding arithmetic and the converters live elsewhere. In this description, "edge 0" is the first rising bit-clock edge at which frame sync is sampled high after having been sampled low. "Edge n" is the n-th rising edge after edge 0. "Period n" is the bit period that starts at edge n.

Top module: `pcm_frame_port`

## Requirements
- R1: After reset, `tx_en`, `tx_data` and `frame_done` are 0 and `rx_word` is 0, and no slot is driven until a frame sync has been seen.
- R2: The mode field is latched at edge 0 with 00 = companded 8-bit, 01 = linear 16-bit, 10 = channel one and 11 = channel two. Channel one drives `tx_word[7:0]` in periods 16 to 23, and channel two drives it in periods 24 to 31.
- R3: In companded mode a long frame carries its 8 bits in periods 0 to 7, and a short frame carries them in periods 1 to 8.
- R4: The width of the sync pulse is the number of rising edges at which frame sync is sampled high. A width of 2 or more selects long frame and a width of 1 selects short frame. The measurement taken in one frame applies to the next companded frame, and short frame applies until the first measurement.
- R5: In the 8-bit modes the bits go out MSB first, starting with `tx_word[7]`.
- R6: Linear mode sends `tx_word[15:2]` MSB first in periods 1 to 14, then two bits driven as 0 in periods 15 and 16.
- R7: Outside its slot `tx_en` is 0 and `tx_data` is 0.
- R8: In a long companded frame, `tx_en` drops during the last bit period as soon as frame sync is low, and it is low for that whole period if sync fell earlier.
- R9: Each slot bit is sampled from `rx_d` on the falling edge inside its period, MSB first. At the falling edge of the last slot bit, `rx_word` takes the assembled word (zero-extended in 8-bit modes) and `frame_done` goes high for exactly one bit period.
- R10: `mode` and `tx_word` are latched at edge 0. Changes to them later in the frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; drives on rising, samples receive data on falling |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | 8 kHz frame sync |
| mode | input | 2 | Frame layout select |
| tx_word | input | 16 | Word to transmit next frame |
| tx_data | output | 1 | Serial transmit bit |
| tx_en | output | 1 | Output enable of the serial transmit pin (0 = high impedance) |
| rx_d | input | 1 | Serial receive bit |
| rx_word | output | 16 | Last received word |
| frame_done | output | 1 | One-period strobe when `rx_word` updates |

## Verification
The bench targets the frame in which the long/short verdict flips. A design that classifies from the current pulse instead of the previous one would shift the whole companded word by one period there. It also exercises a sync pulse of width exactly 2. A design with an off-by-one threshold would place that frame in the short position. The long-frame LSB is probed both at the start of its period and just after sync falls mid-period. A design that releases only on a clock edge would keep driving the line past the fall. Mid-frame changes of mode and transmit word, and the two linear pad bits, are checked at the serial output, where a missing latch or an unmasked LSB shows up as a wrong bit.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
   typedef enum logic [1:0] {
      PM_COMP = 2'b00,
      PM_LIN  = 2'b01,
      PM_CH1  = 2'b10,
      PM_CH2  = 2'b11
   } pcm_mode_e;
endpackage

// File: rtl/pcm_fs_meter.sv
// Detects the frame start and measures the sync pulse width.
module pcm_fs_meter #(
   parameter int CNT_W    = 9,
   parameter int LONG_MIN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fsync,
   output logic frame_start,
   output logic long_sel
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             fs_q;
   logic [CNT_W-1:0] hi_cnt;

   assign frame_start = fsync & ~fs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q     <= 1'b0;
         hi_cnt   <= '0;
         long_sel <= 1'b0;
      end else begin
         fs_q <= fsync;
         if (frame_start)
            hi_cnt <= CNT_W'(1);
         else if (fsync && hi_cnt != CNT_MAX)
            hi_cnt <= hi_cnt + 1'b1;
         // verdict taken when sync falls, used by the next frame
         if (!fsync && fs_q)
            long_sel <= (hi_cnt >= CNT_W'(LONG_MIN));
      end
   end
endmodule

// File: rtl/pcm_slot_timer.sv
// Counts bit periods from the frame start and decodes the active slot.
module pcm_slot_timer
   import pcm_port_pkg::*;
#(
   parameter int CNT_W     = 9,
   parameter int CMP_BITS  = 8,
   parameter int LIN_BITS  = 16,
   parameter int LONG_OFS  = 0,
   parameter int SHORT_OFS = 1,
   parameter int LIN_OFS   = 1,
   parameter int CH1_OFS   = 16,
   parameter int CH2_OFS   = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             long_sel,
   input  logic [1:0]       mode_in,
   output logic             active,
   output logic             last,
   output logic [CNT_W-1:0] idx,
   output pcm_mode_e        mode_cur,
   output logic             long_cur
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] pos, nxt_pos, start, len, nxt_idx;
   pcm_mode_e        nxt_mode;
   logic             nxt_long, in_slot;

   always_comb begin
      nxt_pos  = frame_start ? '0 : ((pos == CNT_MAX) ? pos : pos + 1'b1);
      nxt_mode = frame_start ? pcm_mode_e'(mode_in) : mode_cur;
      nxt_long = frame_start ? long_sel : long_cur;
      case (nxt_mode)
         PM_COMP: begin
            start = nxt_long ? CNT_W'(LONG_OFS) : CNT_W'(SHORT_OFS);
            len   = CNT_W'(CMP_BITS);
         end
         PM_LIN: begin
            start = CNT_W'(LIN_OFS);
            len   = CNT_W'(LIN_BITS);
         end
         PM_CH1: begin
            start = CNT_W'(CH1_OFS);
            len   = CNT_W'(CMP_BITS);
         end
         default: begin
            start = CNT_W'(CH2_OFS);
            len   = CNT_W'(CMP_BITS);
         end
      endcase
      nxt_idx = nxt_pos - start;
      in_slot = (nxt_pos >= start) && (nxt_idx < len);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos      <= CNT_MAX;
         mode_cur <= PM_COMP;
         long_cur <= 1'b0;
         active   <= 1'b0;
         last     <= 1'b0;
         idx      <= '0;
      end else begin
         pos      <= nxt_pos;
         mode_cur <= nxt_mode;
         long_cur <= nxt_long;
         active   <= in_slot;
         last     <= in_slot && (nxt_idx == len - 1'b1);
         idx      <= nxt_idx;
      end
   end
endmodule

// File: rtl/pcm_tx_shifter.sv
// Holds the frame's transmit word and selects the bit for the current period.
module pcm_tx_shifter
   import pcm_port_pkg::*;
#(
   parameter int CNT_W     = 9,
   parameter int CMP_BITS  = 8,
   parameter int LIN_BITS  = 16,
   parameter int LIN_FIXED = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [LIN_BITS-1:0] tx_word,
   input  logic                active,
   input  logic                last,
   input  logic [CNT_W-1:0]    idx,
   input  pcm_mode_e           mode_cur,
   input  logic                long_cur,
   input  logic                fsync,
   output logic                tx_data,
   output logic                tx_en
);
   logic [LIN_BITS-1:0] word_q, shifted;
   logic [CNT_W-1:0]    wlen, sh_amt;
   logic                fixed_zone, early_rel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         word_q <= '0;
      else if (load)
         word_q <= tx_word;
   end

   assign wlen    = (mode_cur == PM_LIN) ? CNT_W'(LIN_BITS) : CNT_W'(CMP_BITS);
   assign sh_amt  = wlen - CNT_W'(1) - idx;
   assign shifted = word_q >> sh_amt;

   generate
      if (LIN_FIXED > 0) begin : g_pad
         assign fixed_zone = (mode_cur == PM_LIN) &&
                             (idx >= CNT_W'(LIN_BITS - LIN_FIXED));
      end else begin : g_nopad
         assign fixed_zone = 1'b0;
      end
   endgenerate

   // long frame: last bit lets go of the line when sync is low
   assign early_rel = (mode_cur == PM_COMP) & long_cur & last & ~fsync;
   assign tx_data   = active & ~fixed_zone & shifted[0];
   assign tx_en     = active & ~early_rel;
endmodule

// File: rtl/pcm_rx_capture.sv
// Samples receive bits on the falling edge and publishes the word.
module pcm_rx_capture
   import pcm_port_pkg::*;
#(
   parameter int CMP_BITS = 8,
   parameter int LIN_BITS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_d,
   input  logic                active,
   input  logic                last,
   input  pcm_mode_e           mode_cur,
   output logic [LIN_BITS-1:0] rx_word,
   output logic                frame_done
);
   localparam logic [LIN_BITS-1:0] CMP_MASK =
      {{(LIN_BITS-CMP_BITS){1'b0}}, {CMP_BITS{1'b1}}};

   logic [LIN_BITS-1:0] sh, nxt_sh;

   assign nxt_sh = {sh[LIN_BITS-2:0], rx_d};

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh         <= '0;
         rx_word    <= '0;
         frame_done <= 1'b0;
      end else begin
         frame_done <= active & last;
         if (active)
            sh <= nxt_sh;
         if (active && last)
            rx_word <= (mode_cur == PM_LIN) ? nxt_sh : (nxt_sh & CMP_MASK);
      end
   end
endmodule

// File: rtl/pcm_frame_port.sv
module pcm_frame_port
   import pcm_port_pkg::*;
#(
   parameter int CNT_W     = 9,
   parameter int CMP_BITS  = 8,
   parameter int LIN_BITS  = 16,
   parameter int LIN_FIXED = 2,
   parameter int CH1_OFS   = 16,
   parameter int CH2_OFS   = 24,
   parameter int LONG_MIN  = 2
) (
   input  logic                bclk,
   input  logic                rst_n,
   input  logic                fsync,
   input  logic [1:0]          mode,
   input  logic [LIN_BITS-1:0] tx_word,
   output logic                tx_data,
   output logic                tx_en,
   input  logic                rx_d,
   output logic [LIN_BITS-1:0] rx_word,
   output logic                frame_done
);
   generate
      if (CMP_BITS < 1 || CMP_BITS > LIN_BITS) begin : g_bad_cmp
         $error("CMP_BITS must lie in 1..LIN_BITS");
      end
      if (LIN_FIXED < 0 || LIN_FIXED >= LIN_BITS) begin : g_bad_fix
         $error("LIN_FIXED must be below LIN_BITS");
      end
      if (CH2_OFS + CMP_BITS >= (1 << CNT_W) || LIN_BITS + 1 >= (1 << CNT_W)) begin : g_bad_cnt
         $error("CNT_W too narrow for the slot offsets");
      end
      if (LONG_MIN < 2) begin : g_bad_long
         $error("LONG_MIN must be at least 2");
      end
   endgenerate

   logic             frame_start, long_sel, long_cur;
   logic             slot_active, slot_last;
   logic [CNT_W-1:0] slot_idx;
   pcm_mode_e        mode_cur;

   pcm_fs_meter #(.CNT_W(CNT_W), .LONG_MIN(LONG_MIN)) u_meter (
      .clk(bclk), .rst_n(rst_n), .fsync(fsync),
      .frame_start(frame_start), .long_sel(long_sel)
   );

   pcm_slot_timer #(
      .CNT_W(CNT_W), .CMP_BITS(CMP_BITS), .LIN_BITS(LIN_BITS),
      .CH1_OFS(CH1_OFS), .CH2_OFS(CH2_OFS)
   ) u_timer (
      .clk(bclk), .rst_n(rst_n), .frame_start(frame_start),
      .long_sel(long_sel), .mode_in(mode), .active(slot_active),
      .last(slot_last), .idx(slot_idx), .mode_cur(mode_cur),
      .long_cur(long_cur)
   );

   pcm_tx_shifter #(
      .CNT_W(CNT_W), .CMP_BITS(CMP_BITS), .LIN_BITS(LIN_BITS),
      .LIN_FIXED(LIN_FIXED)
   ) u_tx (
      .clk(bclk), .rst_n(rst_n), .load(frame_start), .tx_word(tx_word),
      .active(slot_active), .last(slot_last), .idx(slot_idx),
      .mode_cur(mode_cur), .long_cur(long_cur), .fsync(fsync),
      .tx_data(tx_data), .tx_en(tx_en)
   );

   pcm_rx_capture #(.CMP_BITS(CMP_BITS), .LIN_BITS(LIN_BITS)) u_rx (
      .clk(bclk), .rst_n(rst_n), .rx_d(rx_d), .active(slot_active),
      .last(slot_last), .mode_cur(mode_cur), .rx_word(rx_word),
      .frame_done(frame_done)
   );
endmodule

// File: rtl/pcm_frame_port_chk.sv
module pcm_frame_port_chk
   import pcm_port_pkg::*;
#(
   parameter int CNT_W     = 9,
   parameter int LIN_BITS  = 16,
   parameter int LIN_FIXED = 2
) (
   input logic             bclk,
   input logic             rst_n,
   input logic             frame_start,
   input logic             slot_active,
   input logic             slot_last,
   input logic [CNT_W-1:0] slot_idx,
   input pcm_mode_e        mode_cur,
   input logic             tx_en,
   input logic             tx_data,
   input logic             frame_done
);
   // R7
   en_in_slot_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      tx_en |-> slot_active);

   // R10
   mode_hold_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      !frame_start |=> $stable(mode_cur));

   // R6
   lin_pad_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      (mode_cur == PM_LIN && tx_en && slot_idx >= CNT_W'(LIN_BITS - LIN_FIXED)) |-> !tx_data);

   // R9
   done_src_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      frame_done |-> (slot_active && slot_last));

   // R9
   done_pulse_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      frame_done |=> !frame_done);
endmodule

bind pcm_frame_port pcm_frame_port_chk #(
   .CNT_W(CNT_W), .LIN_BITS(LIN_BITS), .LIN_FIXED(LIN_FIXED)
) u_chk (
   .bclk(bclk), .rst_n(rst_n), .frame_start(frame_start),
   .slot_active(slot_active), .slot_last(slot_last), .slot_idx(slot_idx),
   .mode_cur(mode_cur), .tx_en(tx_en), .tx_data(tx_data),
   .frame_done(frame_done)
);

// File: tb/tb_pcm_frame_port.sv
module tb_pcm_frame_port;
   localparam int CLK_PERIOD = 40;
   localparam int FLEN = 40;
   localparam int NF   = 12;
   localparam int F0   = 6;

   logic        bclk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fsync = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic [15:0] tx_word = 16'h0;
   logic        rx_d = 1'b0;
   logic        tx_data, tx_en, frame_done;
   logic [15:0] rx_word;

   pcm_frame_port dut (
      .bclk(bclk), .rst_n(rst_n), .fsync(fsync), .mode(mode),
      .tx_word(tx_word), .tx_data(tx_data), .tx_en(tx_en), .rx_d(rx_d),
      .rx_word(rx_word), .frame_done(frame_done)
   );

   always #(CLK_PERIOD/2) bclk = ~bclk;

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   // frame plan
   int          fmode [NF];
   int          fwid  [NF];
   int          flate [NF];
   logic [15:0] fword [NF];
   string       ftag  [NF];

   // reference model state
   int          k = -1;
   int          m_mode = 0;
   bit          m_long = 0, meas_long = 0, prev_fs = 0;
   int          hi = 0;
   logic [15:0] m_word = '0, acc = '0, pend_word = '0, exp_rx = '0;
   bit          pend = 0, act = 0, lastb = 0;
   int          fidx = -1;
   string       tag = "R1";
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input bit ok, input string req, input string what,
                      input int got, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d (t=%0t)", req, what, got, exp, $time);
      end
   endtask

   task automatic model_step();
      bit fs, start, exp_en, exp_bit, done_exp;
      int s, w, idx;
      string rq;
      fs = fsync;
      start = fs && !prev_fs;
      done_exp = pend;
      if (pend) exp_rx = pend_word;
      pend = 0;
      if (start) begin
         k = 0; m_mode = int'(mode); m_long = meas_long; m_word = tx_word; hi = 1;
         fidx++;
         tag = (fidx < NF) ? ftag[fidx] : "R7";
      end else begin
         if (k >= 0 && k < 100000) k++;
         if (fs) hi++;
      end
      if (!fs && prev_fs) meas_long = (hi >= 2);
      prev_fs = fs;
      case (m_mode)
         0: begin s = m_long ? 0 : 1; w = 8; end
         1: begin s = 1; w = 16; end
         2: begin s = 16; w = 8; end
         default: begin s = 24; w = 8; end
      endcase
      act = (k >= 0) && (k >= s) && (k < s + w);
      idx = k - s;
      lastb = act && (idx == w - 1);
      if (!act) exp_bit = 0;
      else if (m_mode == 1) exp_bit = (idx >= 14) ? 1'b0 : m_word[15 - idx];
      else exp_bit = m_word[7 - idx];
      exp_en = act && !(m_mode == 0 && m_long && lastb && !fs);
      if (!act) rq = "R7"; else if (m_mode == 0) rq = "R3"; else rq = "R2";
      chk(tx_en == exp_en, {rq, "/", tag}, "tx_en", int'(tx_en), int'(exp_en));
      if (!act) rq = "R7"; else if (m_mode == 0) rq = "R5";
      else if (m_mode == 1) rq = "R6"; else rq = "R2";
      if (exp_en || !act)
         chk(tx_data == exp_bit, {rq, "/", tag}, "tx_data", int'(tx_data), int'(exp_bit));
      chk(frame_done == done_exp, {"R9/", tag}, "frame_done", int'(frame_done), int'(done_exp));
      chk(rx_word == exp_rx, {"R9/", tag}, "rx_word", int'(rx_word), int'(exp_rx));
      if (act) begin
         acc = {acc[14:0], rx_d};
         if (lastb) begin
            pend = 1;
            pend_word = (m_mode == 1) ? acc : (acc & 16'h00FF);
         end
      end
   endtask

   task automatic late_step();
      bit exp_en;
      exp_en = act && !(m_mode == 0 && m_long && lastb && !fsync);
      chk(tx_en == exp_en, {"R8/", tag}, "tx_en after sync change", int'(tx_en), int'(exp_en));
   endtask

   task automatic drive(input int e);
      int f, c;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rx_d = lfsr[0];
      if (e >= F0) begin
         f = (e - F0) / FLEN;
         c = (e - F0) % FLEN;
         if (f < NF) begin
            fsync = (c < fwid[f]);
            // R10: mode and word change late in frame 9
            mode = (c < flate[f]) ? 2'(fmode[f]) : 2'(fmode[f] ^ 1);
            tx_word = (c < flate[f]) ? fword[f] : ~fword[f];
         end else begin
            fsync = 1'b0;
         end
      end
   endtask

   initial begin
      fmode = '{0,0,0,0,0,0,1,2,3,0,3,0};
      fwid  = '{1,8,8,3,1,1,1,1,1,1,2,2};
      flate = '{40,40,40,40,40,40,40,40,40,5,40,40};
      fword = '{16'h00A5,16'h003C,16'h00C3,16'h0096,16'h005A,16'h00E1,
                16'hB7D9,16'h006B,16'h00D2,16'h0071,16'h004E,16'h00B8};
      ftag  = '{"R3","R4","R8","R8","R4","R3","R6","R2","R2","R10","R4","R4"};
      for (int cyc = 0; cyc < F0 + NF * FLEN + 4; cyc++) begin
         @(posedge bclk);
         #(CLK_PERIOD/4);
         if (!rst_n) begin
            chk(tx_en == 1'b0, "R1", "tx_en in reset", int'(tx_en), 0);
            chk(frame_done == 1'b0, "R1", "frame_done in reset", int'(frame_done), 0);
            chk(rx_word == 16'h0, "R1", "rx_word in reset", int'(rx_word), 0);
         end else begin
            model_step();
         end
         #(CLK_PERIOD/2);
         if (cyc == 3) rst_n = 1'b1;
         drive(cyc + 1);
         #(CLK_PERIOD/8);
         if (rst_n) late_step();
      end
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run hung before R9 frames completed");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule